// File: doc/BRIEF.md
# Accumulator Multiply/Divide Unit

This block performs unsigned 16-bit multiplication and division over several clock cycles and leaves every result in a private pair of accumulator registers, one high and one low. It never writes a general register itself. A separate read-out path selects either accumulator, so that the processor's move-from-high and move-from-low operations can copy it into a destination register.

An operation begins with a single-cycle start strobe while the unit is idle. The first operand always comes from a register. The second comes from a register, or from an immediate when the immediate-select input is high. Multiplication uses shift-and-add and division uses restoring division. Both take one bit per clock, and both finish in a fixed number of cycles whatever the operand values. The accumulators keep their old contents for the whole operation and change only in the cycle that completes it. Completion is marked by a one-cycle done pulse.

Top module: `muldiv_acc`

## Requirements
- R1: After reset, busy, done and div_zero are 0, and both accumulators read 0.
- R2: When start is sampled high while busy is 0, busy is 1 for exactly 16 cycles. In the cycle after the 16th following rising edge, busy is 0 and done is 1.
- R3: When use_imm is 1 the second operand is imm, otherwise src_b. The first operand is always src_a.
- R4: With op_div = 0 the product src_a × operand-B is unsigned. acc_hi receives product bits 31:16 and acc_lo receives bits 15:0.
- R5: With op_div = 1 and a non-zero divisor, acc_lo receives the unsigned quotient src_a / operand-B and acc_hi receives the remainder.
- R6: With op_div = 1 and a zero divisor, acc_lo becomes 0xFFFF, acc_hi becomes the dividend, and div_zero is 1 in the same cycle as done.
- R7: A start strobe while busy is 1 is ignored. The running operation keeps its operands and its completion time.
- R8: acc_hi and acc_lo hold their previous values until the cycle in which done is 1.
- R9: mv_data shows acc_hi when mv_hi is 1 and acc_lo when mv_hi is 0, in the same cycle.
- R10: done and div_zero are single-cycle pulses, and div_zero is never 1 without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| use_imm | input | 1 | Take the second operand from imm instead of src_b |
| src_a | input | 16 | First operand (multiplicand / dividend) |
| src_b | input | 16 | Second operand from a register |
| imm | input | 16 | Second operand as an immediate |
| mv_hi | input | 1 | Read-out select: 1 = high accumulator, 0 = low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | One-cycle divide-by-zero flag, coincident with done |
| acc_hi | output | 16 | High accumulator (product high half / remainder) |
| acc_lo | output | 16 | Low accumulator (product low half / quotient) |
| mv_data | output | 16 | Selected accumulator for a move into a general register |

## Verification
On every cycle, the assertions check the handshake: done comes only after busy, done and div_zero are pulses, an accumulator changes only when done is high, and a start strobe during busy is ignored. Whenever done is high they also check the arithmetic of the completed operation against the operands the unit captured: the product must equal the two factors multiplied, and quotient times divisor plus remainder must equal the dividend with the remainder below the divisor. Only the bench scenarios can show the exact 16-cycle latency, the selection between immediate and register operand, the divide-by-zero result values, and that a start strobe issued in the middle of an operation leaves its result unchanged.

// File: rtl/muldiv_acc.sv
module muldiv_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic         use_imm,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] imm,
  input  logic         mv_hi,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic [W-1:0] mv_data
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  opa_q, opb_q, wh, wl, nh, nl;
  logic [CW-1:0] cnt;
  logic          is_div;

  logic [W-1:0] b_sel;
  assign b_sel = use_imm ? imm : src_b;

  // multiply step: add multiplicand when multiplier LSB set, shift right
  logic [W:0] mul_sum;
  assign mul_sum = {1'b0, wh} + (wl[0] ? {1'b0, opa_q} : '0);

  // restoring divide step: shift in next dividend bit, trial subtract
  logic [W:0] shifted, diff;
  logic       ge;
  assign shifted = {wh, wl[W-1]};
  assign diff    = shifted - {1'b0, opb_q};
  assign ge      = ~diff[W];

  assign nh = is_div ? (ge ? diff[W-1:0] : shifted[W-1:0]) : mul_sum[W:1];
  assign nl = is_div ? {wl[W-2:0], ge} : {mul_sum[0], wl[W-1:1]};

  logic last, dz;
  assign last = (cnt == CW'(W - 1));
  assign dz   = is_div && (opb_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; div_zero <= 1'b0;
      acc_hi <= '0; acc_lo <= '0;
      opa_q <= '0; opb_q <= '0; wh <= '0; wl <= '0;
      cnt <= '0; is_div <= 1'b0;
    end else begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      if (!busy) begin
        if (start) begin
          opa_q  <= src_a;
          opb_q  <= b_sel;
          is_div <= op_div;
          wh     <= '0;
          wl     <= op_div ? src_a : b_sel;
          cnt    <= '0;
          busy   <= 1'b1;
        end
      end else begin
        wh  <= nh;
        wl  <= nl;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          div_zero <= dz;
          acc_hi   <= dz ? opa_q : nh;
          acc_lo   <= dz ? '1 : nl;
        end
      end
    end
  end

  assign mv_data = mv_hi ? acc_hi : acc_lo;

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && $stable(opa_q) && $stable(opb_q) && $stable(is_div)));
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(acc_hi) || !$stable(acc_lo)) |-> done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_dz_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done);
  a_r4_product: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_div) |-> ({acc_hi, acc_lo} == (2*W)'(opa_q) * (2*W)'(opb_q)));
  a_r5_quot_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_div && !div_zero) |->
      (((2*W)'(acc_lo) * (2*W)'(opb_q) + (2*W)'(acc_hi) == (2*W)'(opa_q)) && (acc_hi < opb_q)));
endmodule

// File: tb/tb_muldiv_acc.sv
module tb_muldiv_acc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_div = 1'b0, use_imm = 1'b0, mv_hi = 1'b0;
  logic [15:0] src_a = '0, src_b = '0, imm = '0;
  logic busy, done, div_zero;
  logic [15:0] acc_hi, acc_lo, mv_data;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  muldiv_acc dut (.clk, .rst_n, .start, .op_div, .use_imm, .src_a, .src_b, .imm,
                  .mv_hi, .busy, .done, .div_zero, .acc_hi, .acc_lo, .mv_data);

  function automatic logic [31:0] expect_res(input logic dv, input logic [15:0] a, input logic [15:0] b);
    if (!dv) return 32'(a) * 32'(b);
    if (b == 16'd0) return {a, 16'hFFFF};
    return {a % b, a / b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic dv, input logic ui, input logic [15:0] a,
                        input logic [15:0] b, input logic [15:0] im, input bit inject);
    logic [31:0] prev, exp;
    logic [15:0] bsel;
    bsel = ui ? im : b;
    exp  = expect_res(dv, a, bsel);
    prev = {acc_hi, acc_lo};
    @(negedge clk);
    start = 1'b1; op_div = dv; use_imm = ui; src_a = a; src_b = b; imm = im;
    @(negedge clk);
    start = 1'b0; src_a = ~a; src_b = ~b; imm = ~im; op_div = ~dv; use_imm = ~ui;
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    for (int i = 1; i <= 16; i++) begin
      if (inject && i == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (i < 16) begin
        if (busy !== 1'b1 || done !== 1'b0) chk("R2/R7 busy window", {30'd0, busy, done}, 32'd2);
        if ({acc_hi, acc_lo} !== prev) chk("R8 acc hold", {acc_hi, acc_lo}, prev);
      end
    end
    chk("R2 done at cycle 16", {30'd0, busy, done}, 32'd1);
    chk(dv ? (bsel == 0 ? "R6 div zero result" : "R5 quotient/remainder") : "R4 product",
        {acc_hi, acc_lo}, exp);
    if (inject) chk("R7 start while busy ignored", {acc_hi, acc_lo}, exp);
    if (ui) chk("R3 immediate operand", {acc_hi, acc_lo}, exp);
    chk("R6 div_zero flag", {31'd0, div_zero}, {31'd0, dv && bsel == 0});
    mv_hi = 1'b1; #1;
    chk("R9 move high", {16'd0, mv_data}, {16'd0, exp[31:16]});
    mv_hi = 1'b0; #1;
    chk("R9 move low", {16'd0, mv_data}, {16'd0, exp[15:0]});
    @(negedge clk);
    chk("R10 pulses end", {30'd0, done, div_zero}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, busy, done, div_zero, 1'b0}, 32'd0);
    chk("R1 reset accumulators", {acc_hi, acc_lo}, 32'd0);
    rst_n = 1'b1;
    run_op(1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0, 1'b0);
    run_op(1'b0, 1'b1, 16'h1234, 16'hAAAA, 16'd6, 1'b0);
    run_op(1'b0, 1'b0, 16'h8000, 16'h0000, 16'h0, 1'b0);
    run_op(1'b1, 1'b0, 16'd1000, 16'd7, 16'h0, 1'b0);
    run_op(1'b1, 1'b1, 16'hFFFF, 16'h0, 16'd4, 1'b0);
    run_op(1'b1, 1'b0, 16'hBEEF, 16'h0, 16'h5, 1'b0);
    run_op(1'b1, 1'b0, 16'd5, 16'd9, 16'h0, 1'b0);
    run_op(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0, 1'b0);
    run_op(1'b0, 1'b0, 16'd300, 16'd301, 16'h0, 1'b1);
    run_op(1'b1, 1'b0, 16'd999, 16'd10, 16'h0, 1'b1);
    for (int k = 0; k < 60; k++) begin
      logic [15:0] rb;
      rb = 16'($urandom);
      if (k % 7 == 0) rb = 16'd0;
      run_op(1'($urandom), 1'($urandom), 16'($urandom), rb, 16'($urandom), (k % 5) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule